// File: doc/BRIEF.md
# Complex-Arithmetic Custom Opcode Decoder

This block inspects 32-bit R-type instruction words and claims the ones that carry the custom-0 major opcode, which here encodes a small complex-number arithmetic extension. For a claimed word it extracts the register fields, checks the function fields for legality and emits the control a datapath needs: register-file read enables for both sources, a destination write enable, an illegal-instruction flag, operand-source selects and an encoded ALU operation.

Words with any other major opcode are not touched. The block reports them as not handled and drives every enable low, so that a base-ISA decoder next to it can own them. All outputs are registered, so a result appears one clock after its instruction is presented.

Top module: `cx_insn_decoder`

## Requirements
- R1: A valid word whose bits [6:0] equal 7'h0B (with bits [1:0] = 2'b11) sets out_handled one cycle later. Any other opcode, including 7'h0A, 7'h2B and 7'h33, leaves out_handled at 0.
- R2: Under the custom opcode, with funct7 zero, funct3 (bits [14:12]) 3'b000 gives out_alu_op 2'd1 (multiply), 3'b001 gives 2'd2 (add) and 3'b010 gives 2'd3 (magnitude squared).
- R3: Under the custom opcode, funct3 values 3'b011 through 3'b111 set out_illegal and give out_alu_op 2'd0.
- R4: Under the custom opcode, a nonzero funct7 (bits [31:25]) sets out_illegal and gives out_alu_op 2'd0, whatever funct3 holds.
- R5: An illegal word drives out_rd_we, out_rs1_en and out_rs2_en low and all three address outputs to zero.
- R6: For magnitude squared, out_rs2_en is 0 and out_rs2_addr is 0 whatever bits [24:20] hold; the rs2 field never makes the word illegal.
- R7: For legal multiply and add, out_rs1_en, out_rs2_en and out_rd_we are all 1, out_rs1_addr, out_rs2_addr and out_rd_addr carry bits [19:15], [24:20] and [11:7], and both operand selects read 0 (register source). For magnitude squared out_rs1_en, out_rd_we and the rs1 and rd addresses behave the same way.
- R8: For a word that is not handled, out_illegal, out_rd_we, out_rs1_en, out_rs2_en, out_alu_op and all addresses are 0.
- R9: out_valid follows in_valid with one cycle of latency; a cycle with in_valid low yields out_valid 0 and every other output 0 on the next cycle.
- R10: While rst is high, every output is 0 on the clock edges it spans, whatever is on the inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Instruction word present this cycle |
| in_instr | input | 32 | Instruction word |
| out_valid | output | 1 | Decode result present |
| out_handled | output | 1 | Word carries the custom opcode |
| out_illegal | output | 1 | Custom-opcode word with bad function fields |
| out_rs1_en | output | 1 | Read enable for first source register |
| out_rs2_en | output | 1 | Read enable for second source register |
| out_rd_we | output | 1 | Destination register write enable |
| out_opa_sel | output | 1 | Operand A source, 0 = register |
| out_opb_sel | output | 1 | Operand B source, 0 = register |
| out_alu_op | output | 2 | 0 none, 1 multiply, 2 add, 3 magnitude squared |
| out_rs1_addr | output | 5 | First source register index |
| out_rs2_addr | output | 5 | Second source register index |
| out_rd_addr | output | 5 | Destination register index |

## Verification
The assertions assume that in_instr holds a defined word in every cycle where in_valid is high and that rst is held for at least one edge before the first instruction. The stimulus keeps to this by driving inputs only on the falling edge, parking in_instr at a known value during idle cycles, and opening with several reset cycles in which a legal multiply is already on the inputs so that reset must win. Register fields are varied across the whole 0 to 31 range so that the address paths and the ignored rs2 field are exercised with nonzero values.

// File: rtl/cx_dec_pkg.sv
package cx_dec_pkg;
    localparam int ILEN     = 32;
    localparam int REG_AW   = 5;
    localparam int OPC_W    = 7;
    localparam int F3_W     = 3;
    localparam int F7_W     = 7;

    typedef enum logic [1:0] {
        CXOP_NONE = 2'd0,
        CXOP_MUL  = 2'd1,
        CXOP_ADD  = 2'd2,
        CXOP_MAG  = 2'd3
    } cx_op_e;

    typedef enum logic {
        SRC_REG = 1'b0,
        SRC_ALT = 1'b1
    } src_sel_e;

    typedef struct packed {
        logic [F7_W-1:0]   f7;
        logic [REG_AW-1:0] rs2;
        logic [REG_AW-1:0] rs1;
        logic [F3_W-1:0]   f3;
        logic [REG_AW-1:0] rd;
        logic [OPC_W-1:0]  opc;
    } rtype_t;

    typedef struct packed {
        logic              valid;
        logic              handled;
        logic              illegal;
        logic              rs1_en;
        logic              rs2_en;
        logic              rd_we;
        src_sel_e          opa_sel;
        src_sel_e          opb_sel;
        cx_op_e            op;
        logic [REG_AW-1:0] rs1;
        logic [REG_AW-1:0] rs2;
        logic [REG_AW-1:0] rd;
    } dec_ctrl_t;

    function automatic cx_op_e f3_to_op(input logic [F3_W-1:0] f3);
        case (f3)
            3'b000:  return CXOP_MUL;
            3'b001:  return CXOP_ADD;
            3'b010:  return CXOP_MAG;
            default: return CXOP_NONE;
        endcase
    endfunction

    function automatic logic op_uses_rs2(input cx_op_e op);
        return (op == CXOP_MUL) || (op == CXOP_ADD);
    endfunction
endpackage

// File: rtl/cx_field_split.sv
module cx_field_split
    import cx_dec_pkg::*;
(
    input  logic [ILEN-1:0] instr,
    output rtype_t          fields
);
    assign fields = rtype_t'(instr);
endmodule

// File: rtl/cx_op_map.sv
module cx_op_map
    import cx_dec_pkg::*;
#(
    parameter logic [OPC_W-1:0] CUSTOM_OPC = 7'h0B
) (
    input  rtype_t fields,
    output logic   hit,
    output logic   legal,
    output cx_op_e op
);
    cx_op_e raw_op;

    always_comb begin
        hit    = (fields.opc == CUSTOM_OPC);
        raw_op = f3_to_op(fields.f3);
        legal  = hit && (raw_op != CXOP_NONE) && (fields.f7 == '0);
        op     = legal ? raw_op : CXOP_NONE;
    end
endmodule

// File: rtl/cx_ctrl_gen.sv
module cx_ctrl_gen
    import cx_dec_pkg::*;
(
    input  logic      valid,
    input  logic      hit,
    input  logic      legal,
    input  cx_op_e    op,
    input  rtype_t    fields,
    output dec_ctrl_t ctrl
);
    logic go;

    always_comb begin
        go            = valid && legal;
        ctrl          = '0;
        ctrl.valid    = valid;
        ctrl.handled  = valid && hit;
        ctrl.illegal  = valid && hit && !legal;
        ctrl.opa_sel  = SRC_REG;
        ctrl.opb_sel  = SRC_REG;
        if (go) begin
            ctrl.op     = op;
            ctrl.rs1_en = 1'b1;
            ctrl.rd_we  = 1'b1;
            ctrl.rs2_en = op_uses_rs2(op);
            ctrl.rs1    = fields.rs1;
            ctrl.rd     = fields.rd;
            ctrl.rs2    = op_uses_rs2(op) ? fields.rs2 : '0;
        end
    end
endmodule

// File: rtl/cx_insn_decoder.sv
module cx_insn_decoder
    import cx_dec_pkg::*;
#(
    parameter logic [OPC_W-1:0] CUSTOM_OPC = 7'h0B
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [ILEN-1:0]   in_instr,
    output logic              out_valid,
    output logic              out_handled,
    output logic              out_illegal,
    output logic              out_rs1_en,
    output logic              out_rs2_en,
    output logic              out_rd_we,
    output logic              out_opa_sel,
    output logic              out_opb_sel,
    output logic [1:0]        out_alu_op,
    output logic [REG_AW-1:0] out_rs1_addr,
    output logic [REG_AW-1:0] out_rs2_addr,
    output logic [REG_AW-1:0] out_rd_addr
);
    rtype_t    fields;
    logic      hit;
    logic      legal;
    cx_op_e    op;
    dec_ctrl_t ctrl_d;
    dec_ctrl_t ctrl_q;

    cx_field_split u_split (
        .instr  (in_instr),
        .fields (fields)
    );

    cx_op_map #(.CUSTOM_OPC(CUSTOM_OPC)) u_map (
        .fields (fields),
        .hit    (hit),
        .legal  (legal),
        .op     (op)
    );

    cx_ctrl_gen u_ctrl (
        .valid  (in_valid),
        .hit    (hit),
        .legal  (legal),
        .op     (op),
        .fields (fields),
        .ctrl   (ctrl_d)
    );

    always_ff @(posedge clk) begin
        if (rst) ctrl_q <= '0;
        else     ctrl_q <= ctrl_d;
    end

    assign out_valid    = ctrl_q.valid;
    assign out_handled  = ctrl_q.handled;
    assign out_illegal  = ctrl_q.illegal;
    assign out_rs1_en   = ctrl_q.rs1_en;
    assign out_rs2_en   = ctrl_q.rs2_en;
    assign out_rd_we    = ctrl_q.rd_we;
    assign out_opa_sel  = ctrl_q.opa_sel;
    assign out_opb_sel  = ctrl_q.opb_sel;
    assign out_alu_op   = ctrl_q.op;
    assign out_rs1_addr = ctrl_q.rs1;
    assign out_rs2_addr = ctrl_q.rs2;
    assign out_rd_addr  = ctrl_q.rd;

    // R1
    foreign_opc_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_instr[6:0] != CUSTOM_OPC) |=> !out_handled);

    // R5
    illegal_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        out_illegal |-> (!out_rd_we && !out_rs1_en && !out_rs2_en && out_alu_op == 2'd0));

    // R6
    mag_no_rs2_chk: assert property (@(posedge clk) disable iff (rst)
        (out_alu_op == CXOP_MAG) |-> (!out_rs2_en && out_rs2_addr == '0));

    // R8
    unhandled_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !out_handled |-> (!out_illegal && !out_rd_we && !out_rs1_en && !out_rs2_en));

    // R9
    valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    // R9
    idle_follow_chk: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> (!out_valid && !out_handled && !out_rd_we));

    // R2
    op_needs_claim_chk: assert property (@(posedge clk) disable iff (rst)
        (out_alu_op != 2'd0) |-> (out_handled && !out_illegal && out_rd_we));
endmodule

// File: tb/cx_insn_decoder_bench.sv
module cx_insn_decoder_bench;
    typedef struct packed {
        logic       valid, handled, illegal, ra, rb, we, sa, sb;
        logic [1:0] op;
        logic [4:0] a1, a2, ad;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [31:0] in_instr = '0;
    logic        out_valid, out_handled, out_illegal, out_rs1_en, out_rs2_en, out_rd_we;
    logic        out_opa_sel, out_opb_sel;
    logic [1:0]  out_alu_op;
    logic [4:0]  out_rs1_addr, out_rs2_addr, out_rd_addr;

    int n_vec  = 0;
    int n_fail = 0;
    exp_t q[$];
    logic monitor_on = 1'b0;
    bit   done = 1'b0;

    always #2.5 clk = ~clk;

    cx_insn_decoder u_cx_insn_decoder (
        .clk, .rst, .in_valid, .in_instr,
        .out_valid, .out_handled, .out_illegal, .out_rs1_en, .out_rs2_en, .out_rd_we,
        .out_opa_sel, .out_opb_sel, .out_alu_op,
        .out_rs1_addr, .out_rs2_addr, .out_rd_addr
    );

    function automatic logic [31:0] mk(input logic [6:0] f7, input logic [4:0] rs2,
        input logic [4:0] rs1, input logic [2:0] f3, input logic [4:0] rd, input logic [6:0] opc);
        return {f7, rs2, rs1, f3, rd, opc};
    endfunction

    // Expected result taken from the requirement text.
    function automatic exp_t model(input logic v, input logic [31:0] w);
        exp_t e = '0;
        logic claimed, ok;
        logic [1:0] op;
        e.valid = v;
        if (!v) return e;                                // R9
        claimed = (w[6:0] == 7'h0B);                      // R1
        case (w[14:12])
            3'b000: op = 2'd1; 3'b001: op = 2'd2; 3'b010: op = 2'd3;   // R2
            default: op = 2'd0;                                        // R3
        endcase
        ok = claimed && op != 0 && w[31:25] == 0;         // R4
        e.handled = claimed;
        e.illegal = claimed && !ok;                       // R5
        if (ok) begin                                     // R7
            e.op = op; e.ra = 1; e.we = 1;
            e.a1 = w[19:15]; e.ad = w[11:7];
            e.rb = (op != 2'd3);                          // R6
            e.a2 = e.rb ? w[24:20] : 5'd0;
        end
        return e;
    endfunction

    function automatic exp_t observed();
        exp_t o;
        o = {out_valid, out_handled, out_illegal, out_rs1_en, out_rs2_en, out_rd_we,
             out_opa_sel, out_opb_sel, out_alu_op, out_rs1_addr, out_rs2_addr, out_rd_addr};
        return o;
    endfunction

    task automatic drive(input logic v, input logic [31:0] w, input string tag);
        @(negedge clk);
        in_valid = v;
        in_instr = w;
        q.push_back(model(v, w));
        if (tag.len() == 0) return;
    endtask

    // Monitor: pops one expected item per edge after the driver has pushed it.
    always @(posedge clk) begin
        #1;
        if (monitor_on && q.size() > 0) begin
            exp_t e, o;
            e = q.pop_front();
            o = observed();
            n_vec++;
            if (o !== e) begin
                n_fail++;
                $display("FAIL R1..R9 scoreboard (op=%0d handled=%0b illegal=%0b): actual %h expected %h",
                         e.op, e.handled, e.illegal, o, e);
            end
        end
    end

    initial begin
        #200000;
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
            $finish;
        end
    end

    initial begin
        // R10: reset dominates a legal multiply on the inputs
        @(negedge clk);
        in_valid = 1'b1;
        in_instr = mk(7'd0, 5'd3, 5'd4, 3'b000, 5'd5, 7'h0B);
        for (int i = 0; i < 3; i++) begin
            @(posedge clk); #1;
            n_vec++;
            if (observed() !== '0) begin
                n_fail++;
                $display("FAIL R10 reset: actual %h expected 0", observed());
            end
        end
        @(negedge clk);
        rst = 1'b0;
        in_valid = 1'b0;
        monitor_on = 1'b1;

        // R2 R7 legal operations
        drive(1, mk(7'd0, 5'd7,  5'd9,  3'b000, 5'd31, 7'h0B), "R2 mul");
        drive(1, mk(7'd0, 5'd31, 5'd1,  3'b001, 5'd2,  7'h0B), "R2 add");
        drive(1, mk(7'd0, 5'd0,  5'd17, 3'b010, 5'd8,  7'h0B), "R2 mag");
        // R6 rs2 ignored for magnitude
        drive(1, mk(7'd0, 5'd21, 5'd17, 3'b010, 5'd8,  7'h0B), "R6 mag rs2");
        drive(1, mk(7'd0, 5'd31, 5'd0,  3'b010, 5'd0,  7'h0B), "R6 mag rs2 max");
        // R3 every undefined funct3
        for (int f = 3; f < 8; f++)
            drive(1, mk(7'd0, 5'd4, 5'd5, 3'(f), 5'd6, 7'h0B), "R3");
        // R4 nonzero funct7 on each operation
        drive(1, mk(7'h20, 5'd4, 5'd5, 3'b000, 5'd6, 7'h0B), "R4");
        drive(1, mk(7'h01, 5'd4, 5'd5, 3'b001, 5'd6, 7'h0B), "R4");
        drive(1, mk(7'h40, 5'd0, 5'd5, 3'b010, 5'd6, 7'h0B), "R4");
        // R1 R8 foreign opcodes
        drive(1, mk(7'd0, 5'd4, 5'd5, 3'b000, 5'd6, 7'h33), "R8 op");
        drive(1, mk(7'd0, 5'd4, 5'd5, 3'b001, 5'd6, 7'h2B), "R8 custom1");
        drive(1, mk(7'd0, 5'd4, 5'd5, 3'b000, 5'd6, 7'h0A), "R1 low bits");
        drive(1, mk(7'd0, 5'd4, 5'd5, 3'b010, 5'd6, 7'h4B), "R1 high bit");
        // R9 idle cycle carrying a legal word, then back to back
        drive(0, mk(7'd0, 5'd4, 5'd5, 3'b000, 5'd6, 7'h0B), "R9 idle");
        drive(1, mk(7'd0, 5'd10, 5'd11, 3'b001, 5'd12, 7'h0B), "R9");
        drive(0, 32'h0, "R9 idle");
        // sweep register fields
        for (int r = 0; r < 32; r++)
            drive(1, mk(7'd0, 5'(r), 5'(31 - r), 3'(r % 3), 5'(r ^ 5'h15), 7'h0B), "R7 sweep");
        drive(0, 32'h0, "");
        @(negedge clk);
        @(negedge clk);
        monitor_on = 1'b0;
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end
endmodule